// File: doc/BRIEF.md
# Mask Population Count and Lowest-Set-Index Unit

This unit reduces a 128-bit vector mask register image to a single 64-bit scalar. It runs one of two operations on request: it either counts how many mask elements are set, or it reports the index of the lowest set element. Only elements inside the active window take part. The window starts at the start index and ends before the vector length. When masking is on, an element also takes part only if its bit in the v0 register is set.

The surrounding pipeline decodes the instruction and reads both mask registers. It presents the operands together with a one-cycle start strobe. One cycle later the unit returns a done pulse. On a legal request it also returns a scalar write strobe with the result, a pulse that marks the vector state dirty, and a request to clear the start index. When vector execution is disabled or the vector type is flagged invalid, the unit raises an illegal-instruction flag instead and produces no side effect.

Top module: `mask_scan_unit`

## Requirements
- R1: Mask element i is bit i of the 128-bit input (byte i/8, bit i%8 of the register image), so bit 127 is the highest element.
- R2: With op_i = 0 (count), a legal request returns the number of considered elements whose source bit is 1, zero-extended to 64 bits.
- R3: An element is considered only when start index <= i < vector length. With a vector length of 0, a count returns 0.
- R4: When unmasked_i is 0, an element whose v0 bit is 0 is not considered. When unmasked_i is 1, v0 has no effect.
- R5: With op_i = 1 (find), a legal request returns the lowest considered index whose source bit is 1.
- R6: A find with no considered set bit returns all ones (0xFFFF_FFFF_FFFF_FFFF). This includes a vector length of 0.
- R7: A request made while vec_en_i = 0 or vtype_bad_i = 1 raises illegal_o with done_o. It raises no res_we_o, dirty_o or vstart_clr_o, and it leaves res_o unchanged.
- R8: The cycle after a start strobe, done_o is high. For a legal request, res_we_o, dirty_o and vstart_clr_o are also high, each for exactly that one cycle. None of these outputs, nor illegal_o, is high in a cycle that does not follow a strobe, and after reset all of them and res_o are 0.
- R9: A nonzero start index is legal and still produces the write, dirty and clear pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| op_i | input | 1 | 0 = count set elements, 1 = lowest set index |
| src_mask_i | input | 128 | Source mask register image |
| v0_mask_i | input | 128 | v0 mask register image |
| unmasked_i | input | 1 | 1 = ignore v0 |
| vlen_i | input | 8 | Vector length (0..128) |
| vstart_i | input | 8 | Start index |
| vtype_bad_i | input | 1 | Vector type flagged invalid |
| vec_en_i | input | 1 | Vector execution enabled |
| res_o | output | 64 | Scalar result |
| res_we_o | output | 1 | Scalar write strobe |
| done_o | output | 1 | Request completed |
| illegal_o | output | 1 | Illegal-instruction flag |
| dirty_o | output | 1 | Vector state dirty pulse |
| vstart_clr_o | output | 1 | Clear start index to 0 |

## Verification
The assertions check the handshake on every cycle. Done follows each strobe, and the three side-effect pulses appear only together and only after a strobe. An illegal completion never coincides with a write. A reported index always lies inside the window on a set, enabled element, and a count never exceeds the vector length. The actual counts, the choice of the lowest index, the all-ones miss value, v0 gating, the handling of zero length and nonzero start, and the unchanged result after an illegal request can only be shown by the bench's scenarios, which compare every completion against an independent model.

// File: rtl/mask_scan_pkg.sv
package mask_scan_pkg;
   typedef enum logic {
      SCAN_COUNT = 1'b0,
      SCAN_FIND  = 1'b1
   } scan_op_e;
endpackage

// File: rtl/mask_window_gen.sv
// Builds the per-element participation vector: source bit, v0 gate and
// the [start, length) window combined.
module mask_window_gen #(
   parameter int MASK_W = 128,
   parameter int LEN_W  = $clog2(MASK_W) + 1
) (
   input  logic [MASK_W-1:0] src_i,
   input  logic [MASK_W-1:0] v0_i,
   input  logic              unmasked_i,
   input  logic [LEN_W-1:0]  vlen_i,
   input  logic [LEN_W-1:0]  vstart_i,
   output logic [MASK_W-1:0] act_o
);
   for (genvar gi = 0; gi < MASK_W; gi++) begin : g_elem
      localparam logic [LEN_W-1:0] POS = LEN_W'(gi);
      logic in_win;
      assign in_win     = (POS >= vstart_i) && (POS < vlen_i);
      assign act_o[gi]  = src_i[gi] & (unmasked_i | v0_i[gi]) & in_win;
   end
endmodule

// File: rtl/mask_popcount.sv
// Two-level population count: small groups first, then a sum of groups.
module mask_popcount #(
   parameter int MASK_W = 128,
   parameter int GROUP  = 8,
   parameter int CNT_W  = $clog2(MASK_W) + 1
) (
   input  logic [MASK_W-1:0] bits_i,
   output logic [CNT_W-1:0]  count_o
);
   localparam int N_GRP = MASK_W / GROUP;
   localparam int GRP_W = $clog2(GROUP) + 1;

   if (MASK_W % GROUP != 0) begin : g_bad_group
      $error("mask_popcount: MASK_W must be a multiple of GROUP");
   end

   logic [GRP_W-1:0] grp_cnt [N_GRP];

   for (genvar gg = 0; gg < N_GRP; gg++) begin : g_grp
      always_comb begin
         grp_cnt[gg] = '0;
         for (int b = 0; b < GROUP; b++) begin
            grp_cnt[gg] = grp_cnt[gg] + GRP_W'(bits_i[gg*GROUP + b]);
         end
      end
   end

   always_comb begin
      count_o = '0;
      for (int g = 0; g < N_GRP; g++) begin
         count_o = count_o + CNT_W'(grp_cnt[g]);
      end
   end
endmodule

// File: rtl/mask_find_first.sv
// Priority scan for the lowest set bit.
module mask_find_first #(
   parameter int MASK_W = 128,
   parameter int IDX_W  = $clog2(MASK_W)
) (
   input  logic [MASK_W-1:0] bits_i,
   output logic              found_o,
   output logic [IDX_W-1:0]  idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = MASK_W - 1; i >= 0; i--) begin
         if (bits_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/mask_scan_unit.sv
module mask_scan_unit
   import mask_scan_pkg::*;
#(
   parameter int MASK_W = 128,
   parameter int XLEN   = 64,
   parameter int GROUP  = 8,
   parameter int LEN_W  = $clog2(MASK_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              op_i,
   input  logic [MASK_W-1:0] src_mask_i,
   input  logic [MASK_W-1:0] v0_mask_i,
   input  logic              unmasked_i,
   input  logic [LEN_W-1:0]  vlen_i,
   input  logic [LEN_W-1:0]  vstart_i,
   input  logic              vtype_bad_i,
   input  logic              vec_en_i,
   output logic [XLEN-1:0]   res_o,
   output logic              res_we_o,
   output logic              done_o,
   output logic              illegal_o,
   output logic              dirty_o,
   output logic              vstart_clr_o
);
   localparam int IDX_W = $clog2(MASK_W);
   localparam int CNT_W = LEN_W;

   if ((MASK_W & (MASK_W - 1)) != 0) begin : g_bad_width
      $error("mask_scan_unit: MASK_W must be a power of two");
   end
   if (XLEN < CNT_W) begin : g_bad_xlen
      $error("mask_scan_unit: XLEN too narrow for the count");
   end

   logic [MASK_W-1:0] act_w;
   logic [CNT_W-1:0]  cnt_w;
   logic              found_w;
   logic [IDX_W-1:0]  idx_w;
   logic              bad_req;
   scan_op_e          op_sel;
   logic [XLEN-1:0]   res_next;

   mask_window_gen #(.MASK_W(MASK_W), .LEN_W(LEN_W)) u_win (
      .src_i      (src_mask_i),
      .v0_i       (v0_mask_i),
      .unmasked_i (unmasked_i),
      .vlen_i     (vlen_i),
      .vstart_i   (vstart_i),
      .act_o      (act_w)
   );

   mask_popcount #(.MASK_W(MASK_W), .GROUP(GROUP), .CNT_W(CNT_W)) u_cnt (
      .bits_i  (act_w),
      .count_o (cnt_w)
   );

   mask_find_first #(.MASK_W(MASK_W), .IDX_W(IDX_W)) u_ff (
      .bits_i  (act_w),
      .found_o (found_w),
      .idx_o   (idx_w)
   );

   assign bad_req = vtype_bad_i | ~vec_en_i;
   assign op_sel  = scan_op_e'(op_i);

   always_comb begin
      if (op_sel == SCAN_FIND) begin
         res_next = found_w ? XLEN'(idx_w) : '1;
      end else begin
         res_next = XLEN'(cnt_w);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_o        <= '0;
         res_we_o     <= 1'b0;
         done_o       <= 1'b0;
         illegal_o    <= 1'b0;
         dirty_o      <= 1'b0;
         vstart_clr_o <= 1'b0;
      end else begin
         done_o       <= start_i;
         illegal_o    <= start_i & bad_req;
         res_we_o     <= start_i & ~bad_req;
         dirty_o      <= start_i & ~bad_req;
         vstart_clr_o <= start_i & ~bad_req;
         if (start_i && !bad_req) begin
            res_o <= res_next;
         end
      end
   end

   // R8: completion one cycle after the strobe
   a_r8_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);
   // R8: side effects only after a strobe
   a_r8_pulse_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      (res_we_o || dirty_o || vstart_clr_o || illegal_o) |-> $past(start_i));
   // R8: write, dirty and clear travel together
   a_r8_pulses_together: assert property (@(posedge clk) disable iff (!rst_n)
      res_we_o |-> (dirty_o && vstart_clr_o && done_o));
   // R7: illegal completion has no side effect and keeps the result
   a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (!res_we_o && !dirty_o && !vstart_clr_o && $stable(res_o)));
   // R5, R3: a reported index lies in the window on a set, enabled element
   a_r5_index_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      found_w |-> (LEN_W'(idx_w) >= vstart_i && LEN_W'(idx_w) < vlen_i
                   && src_mask_i[idx_w] && (unmasked_i || v0_mask_i[idx_w])));
   // R3: count is bounded by the vector length
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_w <= vlen_i);
endmodule

// File: tb/sim_mask_scan_unit.sv
module sim_mask_scan_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         op_i = 1'b0;
   logic [127:0] src_mask_i = '0;
   logic [127:0] v0_mask_i = '0;
   logic         unmasked_i = 1'b1;
   logic [7:0]   vlen_i = '0;
   logic [7:0]   vstart_i = '0;
   logic         vtype_bad_i = 1'b0;
   logic         vec_en_i = 1'b1;
   logic [63:0]  res_o;
   logic         res_we_o, done_o, illegal_o, dirty_o, vstart_clr_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [64:0] expq [$];
   string       tagq [$];
   logic [63:0] last_good = '0;

   always #5 clk = ~clk;

   mask_scan_unit u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .src_mask_i(src_mask_i), .v0_mask_i(v0_mask_i), .unmasked_i(unmasked_i),
      .vlen_i(vlen_i), .vstart_i(vstart_i), .vtype_bad_i(vtype_bad_i),
      .vec_en_i(vec_en_i), .res_o(res_o), .res_we_o(res_we_o), .done_o(done_o),
      .illegal_o(illegal_o), .dirty_o(dirty_o), .vstart_clr_o(vstart_clr_o)
   );

   function automatic logic [63:0] model(logic op, logic [127:0] s, logic [127:0] v,
                                         logic unm, int vl, int vs);
      int c = 0;
      int f = -1;
      for (int i = 0; i < 128; i++) begin
         if (i >= vs && i < vl && (unm || v[i]) && s[i]) begin
            c++;
            if (f < 0) f = i;
         end
      end
      if (op) return (f < 0) ? '1 : 64'(f);
      return 64'(c);
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(string tag, logic op, logic [127:0] s, logic [127:0] v,
                        logic unm, int vl, int vs, logic en, logic bad);
      logic ill;
      logic [63:0] r;
      op_i = op; src_mask_i = s; v0_mask_i = v; unmasked_i = unm;
      vlen_i = 8'(vl); vstart_i = 8'(vs); vec_en_i = en; vtype_bad_i = bad;
      start_i = 1'b1;
      ill = bad || !en;
      if (!ill) last_good = model(op, s, v, unm, vl, vs);
      r = last_good;
      expq.push_back({ill, r});
      tagq.push_back(tag);
      @(negedge clk);
   endtask

   task automatic idle(int n);
      start_i = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // monitor: compare every completion against the queue
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (done_o) begin
               if (expq.size() == 0) begin
                  check("R8 unexpected done", 64'(done_o), 64'd0);
               end else begin
                  logic [64:0] e;
                  string t;
                  e = expq.pop_front();
                  t = tagq.pop_front();
                  check({t, " illegal"}, 64'(illegal_o), 64'(e[64]));
                  check({t, " R8 we"}, 64'(res_we_o), 64'(!e[64]));
                  check({t, " R8 dirty"}, 64'(dirty_o), 64'(!e[64]));
                  check({t, " R8 clr"}, 64'(vstart_clr_o), 64'(!e[64]));
                  check({t, " result"}, res_o, e[63:0]);
               end
            end else if (res_we_o || dirty_o || vstart_clr_o || illegal_o) begin
               check("R8 stray pulse", {60'd0, res_we_o, dirty_o, vstart_clr_o, illegal_o}, 64'd0);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [127:0] ones;
      ones = '1;
      repeat (3) @(negedge clk);
      check("R8 reset res", res_o, 64'd0);
      check("R8 reset flags", {59'd0, res_we_o, done_o, illegal_o, dirty_o, vstart_clr_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      apply("R2 count full", 1'b0, ones, '0, 1'b1, 128, 0, 1'b1, 1'b0); idle(1);
      apply("R3 count len4", 1'b0, ones, '0, 1'b1, 4, 0, 1'b1, 1'b0); idle(1);
      apply("R9 count start4", 1'b0, ones, '0, 1'b1, 8, 4, 1'b1, 1'b0); idle(1);
      apply("R4 count v0 55", 1'b0, ones, 128'h55, 1'b0, 8, 0, 1'b1, 1'b0); idle(1);
      apply("R4 unmasked ignores v0", 1'b0, ones, 128'h0, 1'b1, 8, 0, 1'b1, 1'b0); idle(1);
      apply("R1 count sparse", 1'b0, 128'h8889, '0, 1'b1, 16, 0, 1'b1, 1'b0); idle(1);
      apply("R3 count len0", 1'b0, ones, '0, 1'b1, 0, 0, 1'b1, 1'b0); idle(1);
      apply("R5 find bit3", 1'b1, 128'h08, '0, 1'b1, 16, 0, 1'b1, 1'b0); idle(1);
      apply("R6 find none", 1'b1, '0, '0, 1'b1, 16, 0, 1'b1, 1'b0); idle(1);
      apply("R3 find outside len", 1'b1, 128'h20, '0, 1'b1, 4, 0, 1'b1, 1'b0); idle(1);
      apply("R4 find masked", 1'b1, 128'h11, 128'hFC, 1'b0, 8, 0, 1'b1, 1'b0); idle(1);
      apply("R9 find start3", 1'b1, 128'h22, '0, 1'b1, 8, 3, 1'b1, 1'b0); idle(1);
      apply("R6 find len0", 1'b1, ones, '0, 1'b1, 0, 0, 1'b1, 1'b0); idle(1);
      apply("R1 find top bit", 1'b1, {1'b1, 127'd0}, '0, 1'b1, 128, 0, 1'b1, 1'b0); idle(1);
      apply("R7 disabled", 1'b0, ones, '0, 1'b1, 128, 0, 1'b0, 1'b0); idle(1);
      apply("R7 vtype bad", 1'b1, ones, '0, 1'b1, 8, 0, 1'b1, 1'b1); idle(1);
      apply("R2 back to back a", 1'b0, 128'hF0F0, '0, 1'b1, 128, 2, 1'b1, 1'b0);
      apply("R5 back to back b", 1'b1, 128'hF000, 128'hF000, 1'b0, 128, 0, 1'b1, 1'b0);
      idle(4);

      check("R8 queue drained", 64'(expq.size()), 64'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule